// File: doc/BRIEF.md
# Two-Wire Configuration Byte Slave

This block is a slave on a two-wire serial bus that holds a small bank of configuration bytes. A host loads the bank with a block write and reads it back with a block read. The bus lines are oversampled on the system clock. Start and stop conditions restart the protocol engine, and the slave answers only its own 8-bit write and read address values. Its acknowledge and read data go out on a single pull-low drive.

A write transaction carries two leading bytes, a command and a count. The slave acknowledges both and throws them away. The data bytes that follow fill the bank from byte 0 upward. A read transaction returns the number of bank bytes first, then the bank in order. Each transaction starts again at byte 0. The bank contents are visible at all times on a wide output port, so downstream logic can use the fields directly.

Top module: `cfgser_slave`

## Requirements
- R1: After reset, `cfg_bytes` holds the reset image (0xC3 in every byte by default) and `sda_drive_low` is 0.
- R2: Only the 8-bit address values 0xD2 (write) and 0xD3 (read) are acknowledged. Any other address is left unacknowledged, and the slave ignores the rest of that transaction (no acknowledge, no bank change) until the next start.
- R3: In a write, the two bytes after the address are acknowledged and do not change the bank.
- R4: From the third byte after a write address, data bytes go to byte 0, 1, 2, … in order, and each is acknowledged. Byte i appears on `cfg_bytes[8i+7:8i]`. Bits travel MSB first.
- R5: A stop after any complete byte ends the write. Bytes already received stay loaded, and the other bytes keep their previous values.
- R6: Data bytes beyond the last bank byte are acknowledged and discarded.
- R7: In a read, the first byte sent is the bank size (6 by default), followed by bytes 0 to 5, MSB first, each acknowledged by the host.
- R8: A read that continues past the last bank byte returns 0xFF.
- R9: When the host does not acknowledge a read byte, the slave stops driving and stays released until the next start.
- R10: A repeated start without a stop begins a new transaction at the address phase, with the byte position back at 0.
- R11: `sda_drive_low` changes only while SCL is low, so the slave never creates a start or stop itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Serial clock line as seen on the bus |
| sda_in | input | 1 | Serial data line as seen on the bus |
| sda_drive_low | output | 1 | 1 pulls the data line low (open-drain drive) |
| cfg_bytes | output | NUM_BYTES*8 | Bank contents, byte i at bits 8i+7:8i |

## Verification
A wrong byte position appears either on `cfg_bytes` in the cycle after the acknowledge clock edge of the misplaced byte, or in the first read byte, because the size byte must lead. A state machine stuck in the send or acknowledge phase holds the data line low or drives data bits after a host NACK, and this corrupts the very next stop or address byte. An address decoder that accepts too much shows up as an acknowledge bit sampled low on a foreign address, within nine SCL periods of the start.

// File: rtl/cfgser_pkg.sv
package cfgser_pkg;
   localparam int unsigned BYTE_W = 8;

   typedef enum logic [2:0] {
      ST_IDLE,   // waiting for a start
      ST_RECV,   // shifting in an address or data byte
      ST_RACK,   // holding our acknowledge bit
      ST_SEND,   // shifting out a read byte
      ST_HACK    // released, sampling the host acknowledge
   } cfgser_state_e;
endpackage

// File: rtl/cfgser_sync.sv
module cfgser_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic lvl,
   output logic rise,
   output logic fall
);
   logic [STAGES-1:0] chain;
   logic              prev;

   initial begin
      assert (STAGES >= 2) else $error("cfgser_sync: STAGES must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain <= '1;
         prev  <= 1'b1;
      end else begin
         chain <= {chain[STAGES-2:0], din};
         prev  <= chain[STAGES-1];
      end
   end

   assign lvl  = chain[STAGES-1];
   assign rise = lvl & ~prev;
   assign fall = ~lvl & prev;
endmodule

// File: rtl/cfgser_bank.sv
module cfgser_bank #(
   parameter int unsigned NUM_BYTES = 6,
   parameter int unsigned SEL_W     = 3,
   parameter logic [NUM_BYTES*8-1:0] RESET_IMAGE = {NUM_BYTES{8'hC3}}
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   wr_en,
   input  logic [SEL_W-1:0]       wr_sel,
   input  logic [7:0]             wr_data,
   input  logic [SEL_W-1:0]       rd_sel,
   output logic [7:0]             rd_data,
   output logic [NUM_BYTES*8-1:0] image
);
   logic [7:0] regs [NUM_BYTES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_BYTES; i++) regs[i] <= RESET_IMAGE[i*8 +: 8];
      end else if (wr_en) begin
         for (int i = 0; i < NUM_BYTES; i++)
            if (wr_sel == SEL_W'(i)) regs[i] <= wr_data;
      end
   end

   always_comb begin
      rd_data = 8'hFF;
      for (int i = 0; i < NUM_BYTES; i++)
         if (rd_sel == SEL_W'(i)) rd_data = regs[i];
   end

   for (genvar g = 0; g < NUM_BYTES; g++) begin : g_pack
      assign image[g*8 +: 8] = regs[g];
   end

   // A strobe never addresses a byte outside the bank
   assert_sel_in_bank_R6: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (32'(wr_sel) < NUM_BYTES));

   // Bank content only moves after a write strobe
   assert_hold_without_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (image != $past(image)) |-> $past(wr_en));
endmodule

// File: rtl/cfgser_slave.sv
module cfgser_slave
   import cfgser_pkg::*;
#(
   parameter int unsigned NUM_BYTES   = 6,
   parameter logic [6:0]  DEV_ADDR    = 7'h69,
   parameter int unsigned SYNC_STAGES = 2,
   parameter logic [NUM_BYTES*8-1:0] RESET_IMAGE = {NUM_BYTES{8'hC3}}
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   scl_in,
   input  logic                   sda_in,
   output logic                   sda_drive_low,
   output logic [NUM_BYTES*8-1:0] cfg_bytes
);
   localparam int unsigned SEL_W    = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1;
   localparam int unsigned IDX_W    = $clog2(NUM_BYTES + 3);
   localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(NUM_BYTES + 2);
   localparam logic [BYTE_W-1:0] WR_ADDR    = {DEV_ADDR, 1'b0};
   localparam logic [BYTE_W-1:0] RD_ADDR    = {DEV_ADDR, 1'b1};
   localparam logic [BYTE_W-1:0] COUNT_BYTE = BYTE_W'(NUM_BYTES);
   localparam logic [3:0]        BITS       = 4'd8;

   initial begin
      assert (NUM_BYTES >= 1 && NUM_BYTES <= 250)
         else $error("cfgser_slave: NUM_BYTES out of range");
   end

   logic scl_lvl, scl_rise, scl_fall;
   logic sda_lvl, sda_rise, sda_fall;

   cfgser_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
      .clk(clk), .rst_n(rst_n), .din(scl_in),
      .lvl(scl_lvl), .rise(scl_rise), .fall(scl_fall));

   cfgser_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
      .clk(clk), .rst_n(rst_n), .din(sda_in),
      .lvl(sda_lvl), .rise(sda_rise), .fall(sda_fall));

   logic start_det, stop_det;
   assign start_det = scl_lvl & sda_fall;
   assign stop_det  = scl_lvl & sda_rise;

   cfgser_state_e    state;
   logic [3:0]       bit_cnt;
   logic [7:0]       shreg;
   logic [7:0]       tx_sh;
   logic             is_addr;
   logic             rd_mode;
   logic             sda_oe;
   logic [IDX_W-1:0] byte_idx;

   logic             wr_fire;
   logic [SEL_W-1:0] wr_sel, rd_sel;
   logic [7:0]       bank_rd, rd_pick;

   assign wr_fire = (state == ST_RECV) && !start_det && !stop_det && scl_fall &&
                    (bit_cnt == BITS) && !is_addr &&
                    (32'(byte_idx) >= 2) && (32'(byte_idx) < NUM_BYTES + 2);
   assign wr_sel  = SEL_W'(byte_idx - IDX_W'(2));
   assign rd_sel  = SEL_W'(byte_idx - IDX_W'(1));

   cfgser_bank #(.NUM_BYTES(NUM_BYTES), .SEL_W(SEL_W), .RESET_IMAGE(RESET_IMAGE)) u_bank (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_fire), .wr_sel(wr_sel), .wr_data(shreg),
      .rd_sel(rd_sel), .rd_data(bank_rd), .image(cfg_bytes));

   // Read stream: size byte, then the bank, then filler
   always_comb begin
      if (byte_idx == '0)                   rd_pick = COUNT_BYTE;
      else if (32'(byte_idx) <= NUM_BYTES)  rd_pick = bank_rd;
      else                                  rd_pick = 8'hFF;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         bit_cnt  <= '0;
         shreg    <= '0;
         tx_sh    <= '1;
         is_addr  <= 1'b0;
         rd_mode  <= 1'b0;
         sda_oe   <= 1'b0;
         byte_idx <= '0;
      end else if (start_det) begin
         state    <= ST_RECV;
         bit_cnt  <= '0;
         is_addr  <= 1'b1;
         rd_mode  <= 1'b0;
         sda_oe   <= 1'b0;
         byte_idx <= '0;
      end else if (stop_det) begin
         state  <= ST_IDLE;
         sda_oe <= 1'b0;
      end else begin
         unique case (state)
            ST_RECV: begin
               if (scl_rise) begin
                  shreg   <= {shreg[6:0], sda_lvl};
                  bit_cnt <= bit_cnt + 4'd1;
               end else if (scl_fall && bit_cnt == BITS) begin
                  if (is_addr) begin
                     if (shreg == WR_ADDR || shreg == RD_ADDR) begin
                        rd_mode <= shreg[0];
                        sda_oe  <= 1'b1;
                        state   <= ST_RACK;
                     end else begin
                        state <= ST_IDLE;
                     end
                  end else begin
                     sda_oe <= 1'b1;
                     state  <= ST_RACK;
                     if (byte_idx != IDX_LAST) byte_idx <= byte_idx + IDX_W'(1);
                  end
               end
            end
            ST_RACK: begin
               if (scl_fall) begin
                  is_addr <= 1'b0;
                  bit_cnt <= '0;
                  if (rd_mode) begin
                     state  <= ST_SEND;
                     tx_sh  <= rd_pick;
                     sda_oe <= ~rd_pick[7];
                  end else begin
                     state  <= ST_RECV;
                     sda_oe <= 1'b0;
                  end
               end
            end
            ST_SEND: begin
               if (scl_fall) begin
                  bit_cnt <= bit_cnt + 4'd1;
                  if (bit_cnt == 4'd7) begin
                     sda_oe <= 1'b0;
                     state  <= ST_HACK;
                  end else begin
                     tx_sh  <= {tx_sh[6:0], 1'b1};
                     sda_oe <= ~tx_sh[6];
                  end
               end
            end
            ST_HACK: begin
               if (scl_rise) begin
                  if (sda_lvl)                     state    <= ST_IDLE;
                  else if (byte_idx != IDX_LAST)   byte_idx <= byte_idx + IDX_W'(1);
               end else if (scl_fall) begin
                  state   <= ST_SEND;
                  bit_cnt <= '0;
                  tx_sh   <= rd_pick;
                  sda_oe  <= ~rd_pick[7];
               end
            end
            default: ;
         endcase
      end
   end

   assign sda_drive_low = sda_oe;

   // Drive only moves while the clock line is low
   assert_drive_scl_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (sda_oe != $past(sda_oe)) |-> !scl_lvl);

   // Idle slave never holds the line
   assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE) |-> !sda_oe);

   // The first byte of a read is the bank size
   assert_count_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_SEND && $past(state) == ST_RACK) |-> (tx_sh == COUNT_BYTE));

   // A byte is never written on an address phase
   assert_no_addr_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_fire |-> !is_addr && !rd_mode);
endmodule

// File: tb/cfgser_slave_tb.sv
`timescale 1ns/1ps
module cfgser_slave_tb;
   localparam int H = 16;
   localparam logic [47:0] DEF = 48'hC3C3_C3C3_C3C3;
   localparam logic [8:0] ADDR_TAB [8] = '{
      {8'hD2, 1'b1}, {8'hD3, 1'b1}, {8'hD0, 1'b0}, {8'hD6, 1'b0},
      {8'h52, 1'b0}, {8'hD1, 1'b0}, {8'h69, 1'b0}, {8'hFF, 1'b0}};

   logic clk = 1'b0, rst_n = 1'b0, host_scl = 1'b1, host_sda = 1'b1;
   logic sda_bus, sda_drive_low, prev_drv = 1'b0;
   logic [47:0] cfg;
   int n_vec = 0, n_err = 0, drv_glitch = 0;
   logic ack;
   logic [7:0] rb;

   always #2.5 clk = ~clk;
   assign sda_bus = host_sda & ~sda_drive_low;

   cfgser_slave u_dut (
      .clk(clk), .rst_n(rst_n), .scl_in(host_scl), .sda_in(sda_bus),
      .sda_drive_low(sda_drive_low), .cfg_bytes(cfg));

   // R11 monitor: slave drive must not move while SCL is high
   always @(negedge clk) begin
      if (rst_n && host_scl && (sda_drive_low !== prev_drv)) drv_glitch++;
      prev_drv = sda_drive_low;
   end

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic bus_start();
      host_sda = 1'b1; tick(H);
      host_scl = 1'b1; tick(H);
      host_sda = 1'b0; tick(H);
      host_scl = 1'b0; tick(H);
   endtask

   task automatic bus_stop();
      host_sda = 1'b0; tick(H);
      host_scl = 1'b1; tick(H);
      host_sda = 1'b1; tick(H);
   endtask

   task automatic wr_byte(input logic [7:0] b, output logic got_ack);
      for (int i = 7; i >= 0; i--) begin
         host_sda = b[i]; tick(H);
         host_scl = 1'b1; tick(H);
         host_scl = 1'b0;
      end
      host_sda = 1'b1; tick(H);
      host_scl = 1'b1; tick(H/2);
      got_ack = ~sda_bus; tick(H/2);
      host_scl = 1'b0;
   endtask

   task automatic rd_byte(input logic give_ack, output logic [7:0] b);
      host_sda = 1'b1;
      for (int i = 7; i >= 0; i--) begin
         tick(H);
         host_scl = 1'b1; tick(H/2);
         b[i] = sda_bus; tick(H/2);
         host_scl = 1'b0;
      end
      host_sda = ~give_ack; tick(H);
      host_scl = 1'b1; tick(H);
      host_scl = 1'b0; tick(2);
      host_sda = 1'b1;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_vec++; n_err++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
      $finish;
   end

   initial begin
      tick(5);
      // R1: reset state
      check("R1 reset image", cfg, DEF);
      check("R1 drive released", sda_drive_low, 0);
      rst_n = 1'b1; tick(5);

      // Vector table: address decode (R2), read size byte (R7)
      for (int v = 0; v < 8; v++) begin
         bus_start();
         wr_byte(ADDR_TAB[v][8:1], ack);
         check($sformatf("R2 addr %0h ack", ADDR_TAB[v][8:1]), ack, ADDR_TAB[v][0]);
         if (ack && ADDR_TAB[v][1]) begin
            rd_byte(1'b0, rb);
            check("R7 size byte", rb, 8'd6);
         end
         bus_stop();
         check("R2 bank untouched", cfg, DEF);
      end

      // R2: foreign address, following bytes ignored
      bus_start();
      wr_byte(8'hD4, ack); check("R2 foreign addr nack", ack, 0);
      wr_byte(8'h12, ack); check("R2 ignored byte nack", ack, 0);
      wr_byte(8'h34, ack); check("R2 ignored byte nack", ack, 0);
      bus_stop();
      check("R2 bank after foreign", cfg, DEF);

      // R3: command and count only
      bus_start();
      wr_byte(8'hD2, ack); check("R3 addr ack", ack, 1);
      wr_byte(8'hAA, ack); check("R3 command ack", ack, 1);
      wr_byte(8'h55, ack); check("R3 count ack", ack, 1);
      bus_stop();
      check("R3 bank unchanged", cfg, DEF);

      // R4/R5: partial write then stop
      bus_start();
      wr_byte(8'hD2, ack);
      wr_byte(8'h00, ack);
      wr_byte(8'h06, ack);
      wr_byte(8'h11, ack); check("R4 data0 ack", ack, 1);
      wr_byte(8'h22, ack); check("R4 data1 ack", ack, 1);
      wr_byte(8'h33, ack); check("R4 data2 ack", ack, 1);
      bus_stop();
      check("R5 partial write", cfg, 48'hC3C3C3_332211);

      // R4/R6: full write plus two extra bytes
      bus_start();
      wr_byte(8'hD2, ack);
      wr_byte(8'h00, ack);
      wr_byte(8'h06, ack);
      for (int i = 1; i <= 6; i++) wr_byte(8'hA0 + 8'(i), ack);
      wr_byte(8'h5E, ack); check("R6 extra ack", ack, 1);
      wr_byte(8'h5F, ack); check("R6 extra ack", ack, 1);
      bus_stop();
      check("R6 full write, extras dropped", cfg, 48'hA6A5A4A3A2A1);

      // R7/R8: full read and one past the end
      bus_start();
      wr_byte(8'hD3, ack); check("R7 read addr ack", ack, 1);
      rd_byte(1'b1, rb); check("R7 size first", rb, 8'd6);
      for (int i = 1; i <= 6; i++) begin
         rd_byte(1'b1, rb);
         check($sformatf("R7 read byte %0d", i - 1), rb, 8'hA0 + 8'(i));
      end
      rd_byte(1'b0, rb); check("R8 past end", rb, 8'hFF);
      bus_stop();

      // R9: early NACK releases the line
      bus_start();
      wr_byte(8'hD3, ack);
      rd_byte(1'b1, rb); check("R9 size", rb, 8'd6);
      rd_byte(1'b0, rb); check("R9 byte0", rb, 8'hA1);
      rd_byte(1'b0, rb); check("R9 released after nack", rb, 8'hFF);
      check("R9 drive off", sda_drive_low, 0);
      bus_stop();

      // R10: repeated start restarts at byte 0
      bus_start();
      wr_byte(8'hD2, ack); wr_byte(8'h00, ack); wr_byte(8'h06, ack);
      wr_byte(8'h77, ack);
      bus_start();
      wr_byte(8'hD2, ack); check("R10 restart addr ack", ack, 1);
      wr_byte(8'h00, ack); wr_byte(8'h06, ack);
      wr_byte(8'h88, ack); wr_byte(8'h99, ack);
      bus_stop();
      check("R10 rewrite from byte0", cfg, 48'hA6A5A4A3_9988);

      bus_start();
      wr_byte(8'hD2, ack); wr_byte(8'h00, ack); wr_byte(8'h06, ack);
      wr_byte(8'h44, ack);
      bus_start();
      wr_byte(8'hD3, ack); check("R10 restart to read ack", ack, 1);
      rd_byte(1'b1, rb); check("R10 size after restart", rb, 8'd6);
      rd_byte(1'b0, rb); check("R10 byte0 after restart", rb, 8'h44);
      bus_stop();
      check("R10 bank final", cfg, 48'hA6A5A4A3_9944);

      // R11: no drive change while SCL high
      check("R11 drive changes with SCL high", drv_glitch, 0);

      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
      $finish;
   end
endmodule